// File: doc/BRIEF.md
# Width-matching FIFO byte sequencer

This block is the read-side width adapter of a FIFO whose storage holds 18-bit entries made of two 9-bit bytes. At master reset it captures three configuration levels: whether the read port is 9 or 18 bits wide, whether the write port is 9 or 18 bits wide, and which byte of a stored entry leaves first. With a wide read port every accepted read pops one entry and returns it unchanged. With a narrow read port each entry is handed out as two consecutive byte reads. A one-bit phase register selects the byte, and the entry is popped from storage only together with its second byte.

The block also reports occupancy in the units the flag logic counts in. These are bytes when both ports are narrow and whole entries otherwise. A half-consumed entry then counts as a single remaining byte. Read data and its valid strobe are registered. The pop strobe toward storage and the occupancy value are combinational.

Top module: `fifo_width_sequencer`

## Requirements
- R1: The three configuration inputs are sampled on every clock edge while `rstN` is low and held after `rstN` rises. Later changes on those pins have no effect until the next reset.
- R2: Big-endian order (`cfgLittlePin` low at reset) with a narrow read port: the first read of an entry returns bits [17:9] on `rdData[8:0]`, and the second read returns bits [8:0].
- R3: Little-endian order (`cfgLittlePin` high at reset) with a narrow read port: the first read returns bits [8:0], and the second read returns bits [17:9].
- R4: With a narrow read port, `storePop` is high only in the cycle whose accepted read takes the second byte. It is never high on the first byte. `rdData[17:9]` reads zero.
- R5: With a wide read port (`cfgNarrowOutPin` low at reset), every accepted read raises `storePop` in the same cycle and returns the full entry unchanged on `rdData`.
- R6: A read request while `storeValid` is low is ignored. It raises neither `storePop` nor `rdValid`, leaves `rdData` unchanged and does not advance the byte phase.
- R7: A read is accepted when `rdReq` and `storeValid` are both high at a clock edge. `rdValid` is high and `rdData` carries the result during the following cycle. Without an accepted read, `rdValid` is low and `rdData` holds its value.
- R8: `occupancy` equals 2*`wordCount` minus the phase (1 after a first byte has been taken) when both ports are narrow. Otherwise it equals `wordCount`.
- R9: Reset drives `rdValid` and `rdData` to zero and clears the phase. The first narrow read after any reset returns the first byte of the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rstN | input | 1 | Master reset, active low, synchronous |
| cfgNarrowOutPin | input | 1 | 1 selects 9-bit read port (sampled in reset) |
| cfgNarrowInPin | input | 1 | 1 selects 9-bit write port (sampled in reset) |
| cfgLittlePin | input | 1 | 1 selects little-endian byte order (sampled in reset) |
| rdReq | input | 1 | Read request |
| storeValid | input | 1 | Storage has an entry at its head |
| storeData | input | 18 | Head entry of storage |
| wordCount | input | 12 | Entries held in storage |
| storePop | output | 1 | Remove head entry from storage this cycle |
| rdValid | output | 1 | `rdData` carries a fresh read result |
| rdData | output | 18 | Read result |
| occupancy | output | 13 | Fill level in flag units |

## Verification
`storePop` and `occupancy` are combinational, so the bench samples them 1 ns after it drives the inputs and before the next rising edge. `rdValid` and `rdData` pass through one register, so the bench samples them 5 ns after the edge that accepts the request, inside the following cycle. The phase cannot be observed directly. The bench therefore checks it through the byte chosen and the pop raised on the next accepted read, and through `occupancy`.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef struct packed {
    logic narrowOut;
    logic narrowIn;
    logic littleOrder;
  } fwsCfgT;

  typedef struct packed {
    logic accept;
    logic takeHigh;
    logic narrow;
  } fwsStrobeT;

endpackage

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
#(
  parameter int COUNT_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  fwsCfgT             cfgPins,
  input  logic               rdReq,
  input  logic               storeValid,
  input  logic [COUNT_W-1:0] wordCount,
  output fwsCfgT             cfgLatched,
  output fwsStrobeT          stb,
  output logic               storePop,
  output logic [COUNT_W:0]   occupancy
);

  fwsCfgT cfgQ;
  logic   phaseQ;
  logic   accept;
  logic   byteUnits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= cfgPins;
      phaseQ <= 1'b0;
    end else if (accept && cfgQ.narrowOut) begin
      phaseQ <= ~phaseQ;
    end
  end

  assign accept    = rdReq & storeValid;
  assign byteUnits = cfgQ.narrowOut & cfgQ.narrowIn;

  always_comb begin
    stb.accept   = accept;
    stb.narrow   = cfgQ.narrowOut;
    // first byte is the high half in big-endian order
    stb.takeHigh = cfgQ.littleOrder ? phaseQ : ~phaseQ;
    storePop     = accept & (~cfgQ.narrowOut | phaseQ);
  end

  always_comb begin
    if (byteUnits) occupancy = {wordCount, 1'b0} - {{COUNT_W{1'b0}}, phaseQ};
    else           occupancy = {1'b0, wordCount};
  end

  assign cfgLatched = cfgQ;

endmodule

// File: rtl/fws_datapath.sv
module fws_datapath
  import fws_pkg::*;
#(
  parameter int BYTE_W = 9,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwsStrobeT         stb,
  input  logic [WORD_W-1:0] storeData,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);

  logic [BYTE_W-1:0] lane [2];
  logic [BYTE_W-1:0] pickedByte;
  logic [WORD_W-1:0] nextData;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane[g] = storeData[g*BYTE_W +: BYTE_W];
  end

  assign pickedByte = stb.takeHigh ? lane[1] : lane[0];
  assign nextData   = stb.narrow ? {{BYTE_W{1'b0}}, pickedByte} : storeData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.accept;
      if (stb.accept) rdData <= nextData;
    end
  end

endmodule

// File: rtl/fifo_width_sequencer.sv
module fifo_width_sequencer
  import fws_pkg::*;
#(
  parameter int BYTE_W  = 9,
  parameter int COUNT_W = 12,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgNarrowOutPin,
  input  logic               cfgNarrowInPin,
  input  logic               cfgLittlePin,
  input  logic               rdReq,
  input  logic               storeValid,
  input  logic [WORD_W-1:0]  storeData,
  input  logic [COUNT_W-1:0] wordCount,
  output logic               storePop,
  output logic               rdValid,
  output logic [WORD_W-1:0]  rdData,
  output logic [COUNT_W:0]   occupancy
);

  fwsCfgT    cfgPins;
  fwsCfgT    cfgLatched;
  fwsStrobeT stb;
  logic      latchedNarrowOut;
  logic      latchedNarrowIn;
  logic      latchedLittle;

  assign cfgPins = '{narrowOut: cfgNarrowOutPin, narrowIn: cfgNarrowInPin,
                     littleOrder: cfgLittlePin};

  assign latchedNarrowOut = cfgLatched.narrowOut;
  assign latchedNarrowIn  = cfgLatched.narrowIn;
  assign latchedLittle    = cfgLatched.littleOrder;

  fws_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgPins    (cfgPins),
    .rdReq      (rdReq),
    .storeValid (storeValid),
    .wordCount  (wordCount),
    .cfgLatched (cfgLatched),
    .stb        (stb),
    .storePop   (storePop),
    .occupancy  (occupancy)
  );

  fws_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .storeData (storeData),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int BYTE_W = 9,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic              storeValid,
  input logic              storePop,
  input logic              rdValid,
  input logic [WORD_W-1:0] rdData,
  input logic              narrowOut,
  input logic              narrowIn,
  input logic              little
);

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(narrowOut) && $stable(narrowIn) && $stable(little))); // R1

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && narrowOut) |-> (rdData[WORD_W-1:BYTE_W] == '0)); // R4

  AST_WIDE_POPS_EVERY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!narrowOut && rdReq && storeValid) |-> storePop); // R5

  AST_NO_POP_WITHOUT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    !storeValid |-> !storePop); // R6

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && storeValid) |=> !rdValid); // R6

  AST_VALID_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && storeValid) |=> rdValid); // R7

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && storeValid) |=> $stable(rdData)); // R7

  AST_NARROW_POP_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    (narrowOut && storePop) |=> !(storePop && $past(rdReq && storeValid))); // R4

endmodule

bind fifo_width_sequencer fws_checker #(.BYTE_W(BYTE_W)) u_fws_checker (
  .clk        (clk),
  .rstN       (rstN),
  .rdReq      (rdReq),
  .storeValid (storeValid),
  .storePop   (storePop),
  .rdValid    (rdValid),
  .rdData     (rdData),
  .narrowOut  (latchedNarrowOut),
  .narrowIn   (latchedNarrowIn),
  .little     (latchedLittle)
);

// File: tb/fifo_width_sequencer_bench.sv
`timescale 1ns/1ps
module fifo_width_sequencer_bench;

  localparam int BYTE_W  = 9;
  localparam int COUNT_W = 12;
  localparam int WORD_W  = 18;
  localparam logic [17:0] WA = 18'h2B4A5; // high 0x15A, low 0x0A5
  localparam logic [17:0] WB = 18'h1C3F0; // high 0x0E1, low 0x1F0

  // fields: req, valid, data[18], expPop, expValid, expData[18]
  localparam int NVEC = 8;
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b1, 1'b1, WA, 1'b0, 1'b1, 18'h0015A},
    {1'b1, 1'b1, WA, 1'b1, 1'b1, 18'h000A5},
    {1'b1, 1'b0, WB, 1'b0, 1'b0, 18'h000A5},
    {1'b0, 1'b1, WB, 1'b0, 1'b0, 18'h000A5},
    {1'b1, 1'b1, WB, 1'b0, 1'b1, 18'h000E1},
    {1'b1, 1'b0, WB, 1'b0, 1'b0, 18'h000E1},
    {1'b1, 1'b1, WB, 1'b1, 1'b1, 18'h001F0},
    {1'b1, 1'b1, WA, 1'b0, 1'b1, 18'h0015A}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cfgNarrowOutPin = 1'b1;
  logic               cfgNarrowInPin = 1'b1;
  logic               cfgLittlePin = 1'b0;
  logic               rdReq = 1'b0;
  logic               storeValid = 1'b0;
  logic [WORD_W-1:0]  storeData = '0;
  logic [COUNT_W-1:0] wordCount = '0;
  logic               storePop;
  logic               rdValid;
  logic [WORD_W-1:0]  rdData;
  logic [COUNT_W:0]   occupancy;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fifo_width_sequencer #(.BYTE_W(BYTE_W), .COUNT_W(COUNT_W)) u_fifo_width_sequencer (
    .clk(clk), .rstN(rstN), .cfgNarrowOutPin(cfgNarrowOutPin),
    .cfgNarrowInPin(cfgNarrowInPin), .cfgLittlePin(cfgLittlePin),
    .rdReq(rdReq), .storeValid(storeValid), .storeData(storeData),
    .wordCount(wordCount), .storePop(storePop), .rdValid(rdValid),
    .rdData(rdData), .occupancy(occupancy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic nOut, input logic nIn, input logic lit);
    @(posedge clk); #5;
    rstN = 1'b0; rdReq = 1'b0; storeValid = 1'b0;
    cfgNarrowOutPin = nOut; cfgNarrowInPin = nIn; cfgLittlePin = lit;
    @(posedge clk); @(posedge clk); #5;
    rstN = 1'b1;
  endtask

  // drive at posedge+5, check pop 1 ns later, registered outputs 5 ns after next edge
  task automatic step(input string tag, input logic req, input logic vld,
                      input logic [17:0] d, input logic ePop, input logic eVal,
                      input logic [17:0] eData);
    rdReq = req; storeValid = vld; storeData = d;
    #1;
    check({tag, " pop"}, 32'(storePop), 32'(ePop));
    @(posedge clk); #5;
    rdReq = 1'b0; storeValid = 1'b0;
    check({tag, " valid"}, 32'(rdValid), 32'(eVal));
    check({tag, " data"}, 32'(rdData), 32'(eData));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    wordCount = 12'd5;
    // R9 reset state, narrow/narrow big-endian
    doReset(1'b1, 1'b1, 1'b0);
    check("R9 rdValid after reset", 32'(rdValid), 32'd0);
    check("R9 rdData after reset", 32'(rdData), 32'd0);
    #1;
    check("R8 byte occupancy phase 0", 32'(occupancy), 32'd10);

    // R1: pins change after reset, latched config must stay narrow big-endian
    cfgNarrowOutPin = 1'b0; cfgLittlePin = 1'b1; cfgNarrowInPin = 1'b0;

    // table: R1 R2 R4 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R1 R2 R4 R6 R7 vector %0d", i);
      step(tag, VEC[i][39], VEC[i][38], VEC[i][37:20], VEC[i][19], VEC[i][18], VEC[i][17:0]);
    end
    // phase is now 1 after vector 7
    #1;
    check("R8 byte occupancy phase 1", 32'(occupancy), 32'd9);
    check("R1 occupancy still in byte units", 32'(occupancy), 32'd9);

    // R9: mid-word reset clears phase
    doReset(1'b1, 1'b1, 1'b0);
    step("R9 first byte after reset", 1'b1, 1'b1, WB, 1'b0, 1'b1, 18'h000E1);

    // R3 little-endian narrow
    doReset(1'b1, 1'b0, 1'b1);
    step("R3 little first byte", 1'b1, 1'b1, WA, 1'b0, 1'b1, 18'h000A5);
    step("R6 little ignored read", 1'b1, 1'b0, WA, 1'b0, 1'b0, 18'h000A5);
    step("R3 little second byte", 1'b1, 1'b1, WA, 1'b1, 1'b1, 18'h0015A);
    #1;
    check("R8 word units narrow out wide in", 32'(occupancy), 32'd5);

    // R5 wide read port
    doReset(1'b0, 1'b1, 1'b0);
    step("R5 wide word A", 1'b1, 1'b1, WA, 1'b1, 1'b1, WA);
    step("R5 wide word B", 1'b1, 1'b1, WB, 1'b1, 1'b1, WB);
    step("R6 wide ignored read", 1'b1, 1'b0, WA, 1'b0, 1'b0, WB);
    wordCount = 12'd7;
    #1;
    check("R8 word units wide out", 32'(occupancy), 32'd7);

    finish();
  end

endmodule